// File: doc/BRIEF.md
# DRAM ECC Error Logging Registers

This block keeps the error log for a memory controller. The controller's datapath sends it one-cycle pulses. A correctable error pulse or an uncorrectable error pulse comes with the failing 33-bit address, the channel and the 8-bit ECC syndrome. Three other pulses report a refresh timeout, a locked access that targeted non-DRAM memory, and a thermal sensor event. Each pulse sets a sticky status bit. Software clears a status bit by writing a one to it.

The block captures the address, channel and syndrome of one error event, using a fixed precedence. The first correctable error is kept while it stays logged. An uncorrectable error takes over the capture unless an uncorrectable error is already logged. A command register holds one enable per source, and the system-error output rises while any enabled source has its status bit set. Software reaches the registers through a simple port. Writes take effect at the clock edge, and reads are combinational from the registered state.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr` is low.
- R2: A pulse sets its status bit on the next clock edge: correctable error bit 0, uncorrectable error bit 1, refresh timeout bit 8, locked non-DRAM access bit 9, thermal event bit 11. All other status bits read zero. Register offsets: status 0, command 1, address pointer 2, extended pointer 3, syndrome 4.
- R3: Writing a one to a status bit clears it, and writing a zero leaves it alone. An event that arrives in the same cycle as the clearing write leaves its bit set.
- R4: A correctable error that arrives when neither error type is logged captures the address, the channel and the syndrome.
- R5: An uncorrectable error that arrives when no uncorrectable error is logged replaces the captured information, even if a correctable error is logged.
- R6: A correctable error never replaces the capture while either error bit is set. An uncorrectable error does not replace an uncorrectable one that is still logged.
- R7: The pointer register returns address bits 31:7 in bits 31:7, the channel in bit 0, and zero in bits 6:1. The extended pointer returns address bit 32 in bit 0 and zero elsewhere. The syndrome register returns the captured syndrome in bits 7:0.
- R8: The command register stores writes at the five source positions only. All other bits read zero.
- R9: `serr` is high exactly while some status bit and the matching command bit are both set.
- R10: Writes to the pointer, extended pointer and syndrome offsets have no effect. Offsets 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_evt | input | 1 | Correctable ECC error pulse |
| ue_evt | input | 1 | Uncorrectable ECC error pulse |
| err_addr | input | 33 | Failing address for the error pulse |
| err_chan | input | 1 | Failing channel |
| err_syn | input | 8 | ECC syndrome of the error |
| rfto_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Locked access to non-DRAM memory pulse |
| therm_evt | input | 1 | Thermal sensor event pulse |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| serr | output | 1 | System-error output |

## Verification
The bench targets the capture precedence. It sends a second correctable error over a logged one, an uncorrectable error over a correctable one, and a correctable error over an uncorrectable one. A design with the precedence wrong would report the wrong failing address. The bench writes a clear and an event to the same status bit in the same cycle, where a design that let the clear win would lose the event. It writes ones to the reserved status and command bits and writes to the read-only capture offsets, where a leaky decode would change what reads back. It also enables one source while a different one is pending, where a design that only ORs the status bits would raise `serr` wrongly. A stretch of pseudo-random traffic then tests event and write collisions against the reference model on every clock.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the DRAM ECC error log.
// Assumes a 16-bit status/command layout and a 3-bit register offset.
package ecc_log_pkg;
    localparam int STS_W     = 16;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 3;
    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RFTO  = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;
    localparam logic [STS_W-1:0] STS_MASK = STS_W'((1 << BIT_CE) | (1 << BIT_UE) |
        (1 << BIT_RFTO) | (1 << BIT_LOCK) | (1 << BIT_THERM));

    typedef enum logic [REG_AW-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CMD    = 3'd1,
        SEL_PTR    = 3'd2,
        SEL_PTR_HI = 3'd3,
        SEL_SYN    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic therm;
        logic lock;
        logic rfto;
        logic ue;
        logic ce;
    } evt_t;

    // Place each event pulse at its status bit position.
    function automatic logic [STS_W-1:0] evt_to_vec(input evt_t e);
        logic [STS_W-1:0] v;
        v            = '0;
        v[BIT_CE]    = e.ce;
        v[BIT_UE]    = e.ue;
        v[BIT_RFTO]  = e.rfto;
        v[BIT_LOCK]  = e.lock;
        v[BIT_THERM] = e.therm;
        return v;
    endfunction
endpackage

// File: rtl/ecc_log_status.sv
`timescale 1ns/1ps
// Sticky status bits, cleared by writing one.
// Assumes set_vec holds single-cycle pulses. A set beats a clear in the same cycle.
// Bits outside IMPL are constant zero.
module ecc_log_status
    import ecc_log_pkg::*;
#(
    parameter int              W    = STS_W,
    parameter logic [W-1:0]    IMPL = STS_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sts_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic bit_q;
            // Hold one sticky flag: a set wins, otherwise a write of one clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (set_vec[i])
                    bit_q <= 1'b1;
                else if (clr_vec[i])
                    bit_q <= 1'b0;
            end
            assign sts_q[i] = bit_q;
        end else begin : g_rsvd
            assign sts_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
// Captures the address, channel and syndrome of one ECC error event.
// Assumes ce_logged and ue_logged are the status bits before this cycle's
// update. An uncorrectable error takes over unless one is already logged.
// A correctable error is taken only when nothing is logged.
module ecc_log_capture #(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_evt,
    input  logic                       ue_evt,
    input  logic                       ce_logged,
    input  logic                       ue_logged,
    input  logic [ADDR_W-1:GRAIN_LSB]  line_addr,
    input  logic                       err_chan,
    input  logic [SYN_W-1:0]           err_syn,
    output logic [ADDR_W-1:GRAIN_LSB]  cap_addr_q,
    output logic                       cap_chan_q,
    output logic [SYN_W-1:0]           cap_syn_q
);
    logic take_ue;
    logic take_ce;
    logic take;

    // Decide whether this cycle's event owns the capture registers.
    always_comb begin
        take_ue = ue_evt && !ue_logged;
        take_ce = ce_evt && !ce_logged && !ue_logged;
        take    = take_ue || take_ce;
    end

    // Load the capture registers when the current event owns them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_chan_q <= 1'b0;
            cap_syn_q  <= '0;
        end else if (take) begin
            cap_addr_q <= line_addr;
            cap_chan_q <= err_chan;
            cap_syn_q  <= err_syn;
        end
    end
endmodule

// File: rtl/ecc_log_regs.sv
`timescale 1ns/1ps
// Register port: holds the command register, decodes writes to status
// (clear by writing one) and selects the read data.
// Assumes reads are combinational and writes take effect at the clock edge.
// The capture offsets are read-only.
module ecc_log_regs
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [STS_W-1:0]          reg_wdata,
    input  logic [STS_W-1:0]          sts_q,
    input  logic [ADDR_W-1:GRAIN_LSB] cap_addr_q,
    input  logic                      cap_chan_q,
    input  logic [SYN_W-1:0]          cap_syn_q,
    output logic [STS_W-1:0]          cmd_q,
    output logic [STS_W-1:0]          sts_clr,
    output logic [DATA_W-1:0]         reg_rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              wr_sts;
    logic              wr_cmd;
    logic [DATA_W-1:0] ptr_word;
    logic [DATA_W-1:0] ext_word;
    logic [DATA_W-1:0] syn_word;

    // Decode write strobes per register.
    always_comb begin
        wr_sts  = reg_wr && (reg_addr == SEL_STATUS);
        wr_cmd  = reg_wr && (reg_addr == SEL_CMD);
        sts_clr = wr_sts ? (reg_wdata & STS_MASK) : '0;
    end

    // Hold the per-source system-error enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_cmd)
            cmd_q <= reg_wdata & STS_MASK;
    end

    // Format the captured fields into their register words.
    always_comb begin
        ptr_word                       = '0;
        ptr_word[DATA_W-1:GRAIN_LSB]   = cap_addr_q[DATA_W-1:GRAIN_LSB];
        ptr_word[0]                    = cap_chan_q;
        ext_word                       = '0;
        ext_word[HI_W-1:0]             = cap_addr_q[ADDR_W-1:DATA_W];
        syn_word                       = '0;
        syn_word[SYN_W-1:0]            = cap_syn_q;
    end

    // Select the read data by offset. Unmapped offsets read zero.
    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = DATA_W'(sts_q);
            SEL_CMD:    reg_rdata = DATA_W'(cmd_q);
            SEL_PTR:    reg_rdata = ptr_word;
            SEL_PTR_HI: reg_rdata = ext_word;
            SEL_SYN:    reg_rdata = syn_word;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
// DRAM ECC error log top: sticky status, capture with precedence,
// command enables and the system-error output.
// Assumes event inputs are one-cycle pulses and err_* is valid with them.
// Address bits below GRAIN_LSB are not stored.
module ecc_err_log
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7,
    parameter int SYN_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_evt,
    input  logic                 ue_evt,
    input  logic [ADDR_W-1:0]    err_addr,
    input  logic                 err_chan,
    input  logic [SYN_W-1:0]     err_syn,
    input  logic                 rfto_evt,
    input  logic                 lock_evt,
    input  logic                 therm_evt,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [STS_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 serr
);
    evt_t                      evt;
    logic [STS_W-1:0]          sts_set;
    logic [STS_W-1:0]          sts_clr;
    logic [STS_W-1:0]          sts_q;
    logic [STS_W-1:0]          cmd_q;
    logic [ADDR_W-1:GRAIN_LSB] cap_addr_q;
    logic                      cap_chan_q;
    logic [SYN_W-1:0]          cap_syn_q;
    logic                      unused_low_addr;

    // Gather the event pulses into the status set vector.
    always_comb begin
        evt.ce    = ce_evt;
        evt.ue    = ue_evt;
        evt.rfto  = rfto_evt;
        evt.lock  = lock_evt;
        evt.therm = therm_evt;
        sts_set   = evt_to_vec(evt);
    end

    assign unused_low_addr = ^err_addr[GRAIN_LSB-1:0];

    ecc_log_status #(
        .W    (STS_W),
        .IMPL (STS_MASK)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (sts_set),
        .clr_vec (sts_clr),
        .sts_q   (sts_q)
    );

    ecc_log_capture #(
        .ADDR_W    (ADDR_W),
        .GRAIN_LSB (GRAIN_LSB),
        .SYN_W     (SYN_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_evt     (ce_evt),
        .ue_evt     (ue_evt),
        .ce_logged  (sts_q[BIT_CE]),
        .ue_logged  (sts_q[BIT_UE]),
        .line_addr  (err_addr[ADDR_W-1:GRAIN_LSB]),
        .err_chan   (err_chan),
        .err_syn    (err_syn),
        .cap_addr_q (cap_addr_q),
        .cap_chan_q (cap_chan_q),
        .cap_syn_q  (cap_syn_q)
    );

    ecc_log_regs #(
        .ADDR_W    (ADDR_W),
        .GRAIN_LSB (GRAIN_LSB),
        .SYN_W     (SYN_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .sts_q      (sts_q),
        .cap_addr_q (cap_addr_q),
        .cap_chan_q (cap_chan_q),
        .cap_syn_q  (cap_syn_q),
        .cmd_q      (cmd_q),
        .sts_clr    (sts_clr),
        .reg_rdata  (reg_rdata)
    );

    // Raise the system error while any enabled source is pending.
    always_comb begin
        serr = |(sts_q & cmd_q);
    end
endmodule

// File: rtl/ecc_log_chk.sv
`timescale 1ns/1ps
// Assertion checker bound into ecc_err_log. It observes the status,
// command and capture state against the event and write inputs.
module ecc_log_chk
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W    = 33,
    parameter int GRAIN_LSB = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ce_evt,
    input logic                      ue_evt,
    input logic [ADDR_W-1:0]         err_addr,
    input logic                      reg_wr,
    input logic [REG_AW-1:0]         reg_addr,
    input logic [STS_W-1:0]          reg_wdata,
    input logic [STS_W-1:0]          sts_q,
    input logic [STS_W-1:0]          cmd_q,
    input logic [ADDR_W-1:GRAIN_LSB] cap_addr_q,
    input logic                      serr
);
    AST_CE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_evt |=> sts_q[BIT_CE]); // R2

    AST_UE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ue_evt |=> sts_q[BIT_UE]); // R2

    AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[BIT_UE] && !(reg_wr && reg_addr == SEL_STATUS && reg_wdata[BIT_UE]))
        |=> sts_q[BIT_UE]); // R3

    AST_UE_TAKES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt && !sts_q[BIT_UE])
        |=> cap_addr_q == $past(err_addr[ADDR_W-1:GRAIN_LSB])); // R5

    AST_CAPTURE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_evt && !ue_evt) |=> $stable(cap_addr_q)); // R6

    AST_CE_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_evt && !ue_evt && (sts_q[BIT_CE] || sts_q[BIT_UE])) |=> $stable(cap_addr_q)); // R6

    AST_SERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == '0) |-> !serr); // R9
endmodule

bind ecc_err_log ecc_log_chk #(
    .ADDR_W    (ADDR_W),
    .GRAIN_LSB (GRAIN_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_evt     (ce_evt),
    .ue_evt     (ue_evt),
    .err_addr   (err_addr),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sts_q      (sts_q),
    .cmd_q      (cmd_q),
    .cap_addr_q (cap_addr_q),
    .serr       (serr)
);

// File: tb/ecc_err_log_tb.sv
`timescale 1ns/1ps
module ecc_err_log_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 1'b0, ue_evt = 1'b0;
    logic [32:0] err_addr = '0;
    logic        err_chan = 1'b0;
    logic [7:0]  err_syn = '0;
    logic        rfto_evt = 1'b0, lock_evt = 1'b0, therm_evt = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_sts = '0, m_cmd = '0;
    logic [32:0] m_addr = '0;
    logic        m_chan = 1'b0;
    logic [7:0]  m_syn = '0;
    logic [15:0] m_set, m_clr;
    logic        m_take;

    always #2.5 clk = ~clk;

    ecc_err_log u_dut (
        .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
        .err_addr(err_addr), .err_chan(err_chan), .err_syn(err_syn),
        .rfto_evt(rfto_evt), .lock_evt(lock_evt), .therm_evt(therm_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr(serr)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_sts};
            3'd1: return {16'h0, m_cmd};
            3'd2: return {m_addr[31:7], 6'b0, m_chan};
            3'd3: return {31'b0, m_addr[32]};
            3'd4: return {24'b0, m_syn};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R8";
            3'd2: return "R7";
            3'd3: return "R7";
            3'd4: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update, behaviour taken from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sts = '0; m_cmd = '0; m_addr = '0; m_chan = 1'b0; m_syn = '0;
        end else begin
            m_take = (ue_evt && !m_sts[1]) || (ce_evt && !m_sts[0] && !m_sts[1]);
            if (m_take) begin
                m_addr = err_addr; m_chan = err_chan; m_syn = err_syn;
            end
            m_set = {4'b0, therm_evt, 1'b0, lock_evt, rfto_evt, 6'b0, ue_evt, ce_evt};
            m_clr = (reg_wr && reg_addr == 3'd0) ? (reg_wdata & 16'h0B03) : 16'h0;
            m_sts = (m_sts & ~m_clr) | m_set;
            if (reg_wr && reg_addr == 3'd1) m_cmd = reg_wdata & 16'h0B03;
        end
    end

    // Compare against the model on every clock, between edges
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
            chk("R9", {31'b0, serr}, {31'b0, |(m_sts & m_cmd)});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic c, input logic u, input logic rf, input logic lk,
                         input logic th, input logic [32:0] a, input logic ch,
                         input logic [7:0] s);
        @(negedge clk);
        ce_evt = c; ue_evt = u; rfto_evt = rf; lock_evt = lk; therm_evt = th;
        err_addr = a; err_chan = ch; err_syn = s;
        @(negedge clk);
        ce_evt = 1'b0; ue_evt = 1'b0; rfto_evt = 1'b0; lock_evt = 1'b0; therm_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] lfsr;
        do_reset();
        // R1: reset state
        for (int a = 0; a < 5; a++) expect_reg("R1", 3'(a), 32'h0);
        chk("R1 serr", {31'b0, serr}, 32'h0);

        // R4, R7: first correctable error captured
        pulse(1, 0, 0, 0, 0, 33'h1_2345_67FF, 1'b1, 8'h5A);
        expect_reg("R2", 3'd0, 32'h0001);
        expect_reg("R7", 3'd2, 32'h2345_6781);
        expect_reg("R7", 3'd3, 32'h1);
        expect_reg("R4", 3'd4, 32'h5A);
        // R6: second correctable error ignored
        pulse(1, 0, 0, 0, 0, 33'h0_1111_1111, 1'b0, 8'h33);
        expect_reg("R6", 3'd2, 32'h2345_6781);
        expect_reg("R6", 3'd4, 32'h5A);
        // R5: uncorrectable replaces correctable
        pulse(0, 1, 0, 0, 0, 33'h0_ABCD_EF12, 1'b0, 8'hC3);
        expect_reg("R5", 3'd0, 32'h0003);
        expect_reg("R5", 3'd2, 32'hABCD_EF00);
        expect_reg("R5", 3'd3, 32'h0);
        expect_reg("R5", 3'd4, 32'hC3);
        // R6: neither error type overrides a logged uncorrectable
        pulse(1, 0, 0, 0, 0, 33'h1_FFFF_FFFF, 1'b1, 8'h11);
        pulse(0, 1, 0, 0, 0, 33'h1_0000_0080, 1'b1, 8'h77);
        expect_reg("R6", 3'd2, 32'hABCD_EF00);
        expect_reg("R6", 3'd4, 32'hC3);
        // R3: write-one-to-clear
        wr(3'd0, 16'h0001);
        expect_reg("R3", 3'd0, 32'h0002);
        wr(3'd0, 16'h0000);
        expect_reg("R3", 3'd0, 32'h0002);
        wr(3'd0, 16'hFFFF);
        expect_reg("R3", 3'd0, 32'h0000);
        // R4: fresh capture once cleared
        pulse(1, 0, 0, 0, 0, 33'h1_0000_0080, 1'b1, 8'h77);
        expect_reg("R4", 3'd2, 32'h0000_0081);
        expect_reg("R4", 3'd3, 32'h1);
        expect_reg("R4", 3'd4, 32'h77);
        // R2: other sources
        pulse(0, 0, 1, 0, 0, 33'h0, 1'b0, 8'h0);
        pulse(0, 0, 0, 1, 0, 33'h0, 1'b0, 8'h0);
        pulse(0, 0, 0, 0, 1, 33'h0, 1'b0, 8'h0);
        expect_reg("R2", 3'd0, 32'h0B01);
        // R8, R9: command register and system error
        wr(3'd1, 16'hFFFF);
        expect_reg("R8", 3'd1, 32'h0B03);
        chk("R9 enabled", {31'b0, serr}, 32'h1);
        wr(3'd0, 16'hFFFF);
        #1 chk("R9 cleared", {31'b0, serr}, 32'h0);
        wr(3'd1, 16'h0100);
        pulse(0, 0, 0, 1, 0, 33'h0, 1'b0, 8'h0);
        #1 chk("R9 other source", {31'b0, serr}, 32'h0);
        pulse(0, 0, 1, 0, 0, 33'h0, 1'b0, 8'h0);
        #1 chk("R9 matching source", {31'b0, serr}, 32'h1);
        // R10: capture offsets read-only, unmapped offsets read zero
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'hFFFF);
        expect_reg("R10", 3'd2, 32'h0000_0081);
        expect_reg("R10", 3'd3, 32'h1);
        expect_reg("R10", 3'd4, 32'h77);
        expect_reg("R10", 3'd5, 32'h0);
        expect_reg("R10", 3'd7, 32'h0);
        // R3: event and clear in the same cycle, event wins
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'hFFFF; rfto_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rfto_evt = 1'b0;
        expect_reg("R3 collide", 3'd0, 32'h0100);

        // Pseudo-random traffic, checked against the model every clock
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ce_evt    = lfsr[0] & lfsr[3];
            ue_evt    = lfsr[5] & lfsr[6] & lfsr[7];
            rfto_evt  = lfsr[9] & lfsr[10];
            lock_evt  = lfsr[11] & lfsr[2];
            therm_evt = lfsr[19] & lfsr[4];
            err_addr  = {lfsr[8], lfsr};
            err_chan  = lfsr[12];
            err_syn   = lfsr[23:16];
            reg_wr    = lfsr[13] & lfsr[14];
            reg_addr  = lfsr[17:15];
            reg_wdata = lfsr[31:16] ^ lfsr[15:0];
        end
        @(negedge clk);
        ce_evt = 0; ue_evt = 0; rfto_evt = 0; lock_evt = 0; therm_evt = 0; reg_wr = 0;

        // R1: reset mid-run clears everything
        do_reset();
        for (int a = 0; a < 5; a++) expect_reg("R1 rerun", 3'(a), 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule